// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the 13-bit instruction fetch address for a small 4-bit controller core. The address is made of a bank bit, a 4-bit page and an 8-bit step. Decoded one-cycle strobes from the instruction decoder tell the block what to do with that address. It can advance to the next step, arm a page change, take a plain or flag-conditional jump, call a subroutine, call into page zero, return, return and skip one step, or enter an interrupt vector.

A page change is two-part. A page-set strobe loads a pending bank/page pair, and only the jump or call that comes directly after it uses that pair. Any other jump or call stays in the current page. Calls and interrupts save the return point as three 4-bit nibbles, written through a narrow stack-write port over three cycles. Returns read the same three nibbles back through a stack-read port. The stack pointer and the stack storage are outside the block. Stack slots are given relative to the stack pointer.

Top module: `paged_pc_seq`

## Requirements
- R1: After a synchronous reset, and again after any later reset, `fetch_addr` is 0x0100 (bank 0, page 1, step 0), `busy` is low and no page-set is pending.
- R2: A step strobe adds one to the step modulo 256. Bank and page do not change, so step 0xFF wraps to 0x00 in the same page.
- R3: A page-set strobe with a 5-bit argument makes bit 4 the pending bank and bits 3:0 the pending page. The step advances by one as for a step strobe.
- R4: A jump loads the step from `operand`. If the previous accepted strobe was a page-set, bank and page come from the pending pair. Otherwise they stay as they are. Any accepted strobe other than a page-set clears the pending state.
- R5: A conditional jump follows R4 when its condition holds and otherwise advances the step by one. `cjmp_kind` 0 means carry set, 1 carry clear, 2 zero set, 3 zero clear.
- R6: A call keeps the bank, takes its page as R4 does and loads the step from `operand`. It then spends three busy cycles writing stack slots. Slot select 1 (stack pointer − 1) gets the old page, select 2 the upper nibble of the old step + 1, and select 3 its lower nibble, in that order.
- R7: A page-zero call goes to page 0 at step `operand` in the current bank. It pushes the return point as R6 does.
- R8: A return spends three busy cycles reading slot select 0 (low step nibble), then 1 (high step nibble), then 2 (page). Page and step take the restored values at the end of the third cycle, and the bank does not change. Return-and-skip restores the step plus one.
- R9: An interrupt goes to page 1 at step `irq_vec` in the current bank. It pushes the current page and the unmodified current step in the R6 slot order.
- R10: While `busy` is high, every strobe is ignored, and `fetch_addr` changes only on the final read cycle of a return.
- R11: When several strobes are high together, the winner follows the order interrupt, return, return-and-skip, call, page-zero call, jump, conditional jump, page-set, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance to the next step |
| pset_en | input | 1 | Arm a bank/page change |
| pset_arg | input | 5 | Pending bank (bit 4) and page (bits 3:0) |
| jmp_en | input | 1 | Unconditional jump |
| cjmp_en | input | 1 | Conditional jump |
| cjmp_kind | input | 2 | Condition select (see R5) |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| call_en | input | 1 | Subroutine call |
| calz_en | input | 1 | Call into page 0 |
| ret_en | input | 1 | Return |
| rets_en | input | 1 | Return and skip one step |
| irq_en | input | 1 | Interrupt vector entry |
| irq_vec | input | 4 | Interrupt vector step |
| operand | input | 8 | Target step for jumps and calls |
| stk_rd_data | input | 4 | Nibble read from the selected stack slot |
| fetch_addr | output | 13 | {bank, page, step} fetch address |
| busy | output | 1 | Stack transfer in progress |
| stk_wr_en | output | 1 | Stack nibble write strobe |
| stk_wr_sel | output | 2 | Write slot: n means stack pointer − n |
| stk_wr_data | output | 4 | Nibble to write |
| stk_rd_en | output | 1 | Stack nibble read strobe |
| stk_rd_sel | output | 2 | Read slot: n means stack pointer + n |

## Verification
The bench goes after the page-set adjacency rule. It jumps once directly after a page-set and once with a step in between. A design that kept the pending pair alive too long would land in the armed page instead of staying in the current one. It calls from step 0xFF, where a design that incremented only the low nibble or carried into the page would push the wrong return step. It also checks that an interrupt pushes the step unchanged while a call pushes step + 1, and that a three-nibble round trip through a model stack restores the address. Finally, it raises strobes during a busy transfer and raises several strobes together. A design lacking the busy lock or using another priority order would leave the call target or reach a different address.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    localparam int NIB_W  = 4;
    localparam int PAGE_W = NIB_W;
    localparam int STEP_W = 2 * NIB_W;
    localparam int ADDR_W = 1 + PAGE_W + STEP_W;
    localparam int PARG_W = 1 + PAGE_W;

    typedef struct packed {
        logic              bank;
        logic [PAGE_W-1:0] page;
        logic [STEP_W-1:0] step;
    } pc_t;

    typedef enum logic [3:0] {
        OP_NONE, OP_STEP, OP_PSET, OP_JMP, OP_CJMP,
        OP_CALL, OP_CALZ, OP_RET, OP_RETS, OP_IRQ
    } op_e;

    typedef enum logic [1:0] {SQ_IDLE, SQ_PUSH, SQ_POP} sq_e;

    function automatic logic cond_met(input logic [1:0] kind, input logic c, input logic z);
        case (kind)
            2'd0:    return c;
            2'd1:    return !c;
            2'd2:    return z;
            default: return !z;
        endcase
    endfunction
endpackage

// File: rtl/pcseq_arb.sv
module pcseq_arb
    import pcseq_pkg::*;
(
    input  logic step_en,
    input  logic pset_en,
    input  logic jmp_en,
    input  logic cjmp_en,
    input  logic call_en,
    input  logic calz_en,
    input  logic ret_en,
    input  logic rets_en,
    input  logic irq_en,
    output op_e  op
);
    // R11: fixed priority between simultaneous strobes
    always_comb begin
        if (irq_en)       op = OP_IRQ;
        else if (ret_en)  op = OP_RET;
        else if (rets_en) op = OP_RETS;
        else if (call_en) op = OP_CALL;
        else if (calz_en) op = OP_CALZ;
        else if (jmp_en)  op = OP_JMP;
        else if (cjmp_en) op = OP_CJMP;
        else if (pset_en) op = OP_PSET;
        else if (step_en) op = OP_STEP;
        else              op = OP_NONE;
    end
endmodule

// File: rtl/pcseq_ptr.sv
module pcseq_ptr
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [PARG_W-1:0] pset_arg,
    input  logic              cur_bank,
    input  logic [PAGE_W-1:0] cur_page,
    output logic              tgt_bank,
    output logic [PAGE_W-1:0] tgt_page
);
    logic              pend;
    logic              nbank_q;
    logic [PAGE_W-1:0] npage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            nbank_q <= 1'b0;
            npage_q <= '0;
        end else if (op == OP_PSET) begin
            pend    <= 1'b1;
            nbank_q <= pset_arg[PAGE_W];
            npage_q <= pset_arg[PAGE_W-1:0];
        end else if (op != OP_NONE) begin
            pend    <= 1'b0;
            nbank_q <= cur_bank;
            npage_q <= cur_page;
        end
    end

    assign tgt_bank = pend ? nbank_q : cur_bank;
    assign tgt_page = pend ? npage_q : cur_page;

    AST_PSET_ARMS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PSET) |=> (tgt_bank == $past(pset_arg[PAGE_W]) && tgt_page == $past(pset_arg[PAGE_W-1:0]))); // R3
    AST_PEND_DROPS: assert property (@(posedge clk) disable iff (rst)
        (op != OP_NONE && op != OP_PSET) |=> !pend); // R4
endmodule

// File: rtl/pcseq_stk.sv
module pcseq_stk
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_push,
    input  logic              start_pop,
    input  logic              skip,
    input  logic [PAGE_W-1:0] push_page,
    input  logic [STEP_W-1:0] push_step,
    input  logic [NIB_W-1:0]  rd_data,
    output logic              busy,
    output logic              wr_en,
    output logic [1:0]        wr_sel,
    output logic [NIB_W-1:0]  wr_data,
    output logic              rd_en,
    output logic [1:0]        rd_sel,
    output logic              pop_done,
    output logic [PAGE_W-1:0] pop_page,
    output logic [STEP_W-1:0] pop_step
);
    localparam logic [1:0] LAST = 2'd2;

    sq_e               st;
    logic [1:0]        idx;
    logic [PAGE_W-1:0] sv_page;
    logic [STEP_W-1:0] sv_step;
    logic              skip_q;
    logic [NIB_W-1:0]  lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            idx     <= '0;
            sv_page <= '0;
            sv_step <= '0;
            skip_q  <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    idx <= '0;
                    if (start_push) begin
                        st      <= SQ_PUSH;
                        sv_page <= push_page;
                        sv_step <= push_step;
                    end else if (start_pop) begin
                        st     <= SQ_POP;
                        skip_q <= skip;
                    end
                end
                SQ_PUSH: begin
                    if (idx == LAST) st <= SQ_IDLE;
                    else             idx <= 2'(idx + 2'd1);
                end
                default: begin
                    if (idx == 2'd0) lo_q <= rd_data;
                    if (idx == 2'd1) hi_q <= rd_data;
                    if (idx == LAST) st <= SQ_IDLE;
                    else             idx <= 2'(idx + 2'd1);
                end
            endcase
        end
    end

    always_comb begin
        busy   = (st != SQ_IDLE);
        wr_en  = (st == SQ_PUSH);
        wr_sel = 2'(idx + 2'd1);
        case (idx)
            2'd0:    wr_data = sv_page;
            2'd1:    wr_data = sv_step[STEP_W-1:NIB_W];
            default: wr_data = sv_step[NIB_W-1:0];
        endcase
        rd_en    = (st == SQ_POP);
        rd_sel   = idx;
        pop_done = rd_en && (idx == LAST);
        pop_page = rd_data;
        pop_step = STEP_W'({hi_q, lo_q} + STEP_W'(skip_q));
    end

    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en)); // R6
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> (wr_en && wr_sel == 2'd2)); // R6
    AST_POP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd0) |=> (rd_en && rd_sel == 2'd1)); // R8
endmodule

// File: rtl/paged_pc_seq.sv
module paged_pc_seq
    import pcseq_pkg::*;
#(
    parameter logic [PAGE_W-1:0] RESET_PAGE = 4'd1,
    parameter logic [PAGE_W-1:0] IRQ_PAGE   = 4'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              pset_en,
    input  logic [PARG_W-1:0] pset_arg,
    input  logic              jmp_en,
    input  logic              cjmp_en,
    input  logic [1:0]        cjmp_kind,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              call_en,
    input  logic              calz_en,
    input  logic              ret_en,
    input  logic              rets_en,
    input  logic              irq_en,
    input  logic [NIB_W-1:0]  irq_vec,
    input  logic [STEP_W-1:0] operand,
    input  logic [NIB_W-1:0]  stk_rd_data,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              busy,
    output logic              stk_wr_en,
    output logic [1:0]        stk_wr_sel,
    output logic [NIB_W-1:0]  stk_wr_data,
    output logic              stk_rd_en,
    output logic [1:0]        stk_rd_sel
);
    localparam logic [PAGE_W-1:0] ZERO_PAGE = '0;

    pc_t               pc_q, pc_d;
    op_e               op_raw, op_acc;
    logic              busy_i, tgt_bank, start_push, start_pop, pop_done;
    logic [PAGE_W-1:0] tgt_page, pop_page;
    logic [STEP_W-1:0] pop_step, step_inc, push_step;

    pcseq_arb u_arb (
        .step_en(step_en), .pset_en(pset_en), .jmp_en(jmp_en), .cjmp_en(cjmp_en),
        .call_en(call_en), .calz_en(calz_en), .ret_en(ret_en), .rets_en(rets_en),
        .irq_en(irq_en), .op(op_raw)
    );

    assign op_acc = busy_i ? OP_NONE : op_raw;

    pcseq_ptr u_ptr (
        .clk(clk), .rst(rst), .op(op_acc), .pset_arg(pset_arg),
        .cur_bank(pc_q.bank), .cur_page(pc_q.page),
        .tgt_bank(tgt_bank), .tgt_page(tgt_page)
    );

    assign start_pop = (op_acc == OP_RET) || (op_acc == OP_RETS);

    pcseq_stk u_stk (
        .clk(clk), .rst(rst), .start_push(start_push), .start_pop(start_pop),
        .skip(op_acc == OP_RETS), .push_page(pc_q.page), .push_step(push_step),
        .rd_data(stk_rd_data), .busy(busy_i), .wr_en(stk_wr_en), .wr_sel(stk_wr_sel),
        .wr_data(stk_wr_data), .rd_en(stk_rd_en), .rd_sel(stk_rd_sel),
        .pop_done(pop_done), .pop_page(pop_page), .pop_step(pop_step)
    );

    assign step_inc = STEP_W'(pc_q.step + 1'b1);

    always_comb begin
        pc_d       = pc_q;
        start_push = 1'b0;
        push_step  = step_inc;
        case (op_acc)
            OP_STEP, OP_PSET: pc_d.step = step_inc;
            OP_JMP: pc_d = '{bank: tgt_bank, page: tgt_page, step: operand};
            OP_CJMP: begin
                if (cond_met(cjmp_kind, flag_c, flag_z))
                    pc_d = '{bank: tgt_bank, page: tgt_page, step: operand};
                else
                    pc_d.step = step_inc;
            end
            OP_CALL: begin
                pc_d.page  = tgt_page;
                pc_d.step  = operand;
                start_push = 1'b1;
            end
            OP_CALZ: begin
                pc_d.page  = ZERO_PAGE;
                pc_d.step  = operand;
                start_push = 1'b1;
            end
            OP_IRQ: begin
                pc_d.page  = IRQ_PAGE;
                pc_d.step  = STEP_W'(irq_vec);
                start_push = 1'b1;
                push_step  = pc_q.step;
            end
            default: ;
        endcase
        if (pop_done) begin
            pc_d.page = pop_page;
            pc_d.step = pop_step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '{bank: 1'b0, page: RESET_PAGE, step: '0};
        else     pc_q <= pc_d;
    end

    assign fetch_addr = pc_q;
    assign busy       = busy_i;

    AST_STEP_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (op_acc == OP_STEP) |=> ($stable(pc_q.page) && $stable(pc_q.bank))); // R2
    AST_CALZ_PAGE: assert property (@(posedge clk) disable iff (rst)
        (op_acc == OP_CALZ) |=> (pc_q.page == ZERO_PAGE && busy)); // R7
    AST_IRQ_PAGE: assert property (@(posedge clk) disable iff (rst)
        (op_acc == OP_IRQ) |=> (pc_q.page == IRQ_PAGE && $stable(pc_q.bank))); // R9
    AST_RET_BANK: assert property (@(posedge clk) disable iff (rst)
        pop_done |=> $stable(pc_q.bank)); // R8
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !pop_done) |=> $stable(pc_q)); // R10
endmodule

// File: tb/sim_paged_pc_seq.sv
`timescale 1ns/1ps
module sim_paged_pc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en, pset_en, jmp_en, cjmp_en, call_en, calz_en, ret_en, rets_en, irq_en;
    logic        flag_c, flag_z;
    logic [4:0]  pset_arg;
    logic [1:0]  cjmp_kind;
    logic [3:0]  irq_vec;
    logic [7:0]  operand;
    logic [3:0]  stk_rd_data;
    logic [12:0] fetch_addr;
    logic        busy, stk_wr_en, stk_rd_en;
    logic [1:0]  stk_wr_sel, stk_rd_sel;
    logic [3:0]  stk_wr_data;
    logic [3:0]  bslot [0:3] = '{default: 4'h0};
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    paged_pc_seq u0 (
        .clk(clk), .rst(rst), .step_en(step_en), .pset_en(pset_en), .pset_arg(pset_arg),
        .jmp_en(jmp_en), .cjmp_en(cjmp_en), .cjmp_kind(cjmp_kind), .flag_c(flag_c),
        .flag_z(flag_z), .call_en(call_en), .calz_en(calz_en), .ret_en(ret_en),
        .rets_en(rets_en), .irq_en(irq_en), .irq_vec(irq_vec), .operand(operand),
        .stk_rd_data(stk_rd_data), .fetch_addr(fetch_addr), .busy(busy),
        .stk_wr_en(stk_wr_en), .stk_wr_sel(stk_wr_sel), .stk_wr_data(stk_wr_data),
        .stk_rd_en(stk_rd_en), .stk_rd_sel(stk_rd_sel)
    );

    // model stack frame: write select n -> slot 3-n, read select n -> slot n
    assign stk_rd_data = bslot[stk_rd_sel];
    always @(negedge clk) if (stk_wr_en) bslot[2'd3 - stk_wr_sel] <= stk_wr_data;

    // vector: {op, arg, kind, c, z, expected address}
    // op: 0 step, 1 page-set, 2 jump, 3 cond jump, 4 call, 5 page-zero call, 6 ret, 7 ret+skip, 8 irq
    localparam int NV = 28;
    localparam logic [28:0] VEC [0:NV-1] = '{
        {4'd0, 8'h00, 2'd0, 1'b0, 1'b0, 13'h0101},
        {4'd0, 8'h00, 2'd0, 1'b0, 1'b0, 13'h0102},
        {4'd2, 8'h40, 2'd0, 1'b0, 1'b0, 13'h0140},
        {4'd1, 8'h13, 2'd0, 1'b0, 1'b0, 13'h0141},
        {4'd2, 8'h20, 2'd0, 1'b0, 1'b0, 13'h1320},
        {4'd1, 8'h05, 2'd0, 1'b0, 1'b0, 13'h1321},
        {4'd0, 8'h00, 2'd0, 1'b0, 1'b0, 13'h1322},
        {4'd2, 8'h10, 2'd0, 1'b0, 1'b0, 13'h1310},
        {4'd3, 8'h80, 2'd0, 1'b0, 1'b0, 13'h1311},
        {4'd3, 8'h80, 2'd0, 1'b1, 1'b0, 13'h1380},
        {4'd3, 8'h00, 2'd1, 1'b1, 1'b0, 13'h1381},
        {4'd3, 8'h90, 2'd1, 1'b0, 1'b0, 13'h1390},
        {4'd3, 8'hA0, 2'd2, 1'b0, 1'b1, 13'h13A0},
        {4'd3, 8'h00, 2'd3, 1'b0, 1'b1, 13'h13A1},
        {4'd3, 8'hFF, 2'd3, 1'b0, 1'b0, 13'h13FF},
        {4'd0, 8'h00, 2'd0, 1'b0, 1'b0, 13'h1300},
        {4'd1, 8'h02, 2'd0, 1'b0, 1'b0, 13'h1301},
        {4'd4, 8'h55, 2'd0, 1'b0, 1'b0, 13'h1255},
        {4'd6, 8'h00, 2'd0, 1'b0, 1'b0, 13'h1302},
        {4'd1, 8'h07, 2'd0, 1'b0, 1'b0, 13'h1303},
        {4'd5, 8'h30, 2'd0, 1'b0, 1'b0, 13'h1030},
        {4'd7, 8'h00, 2'd0, 1'b0, 1'b0, 13'h1305},
        {4'd8, 8'h05, 2'd0, 1'b0, 1'b0, 13'h1105},
        {4'd6, 8'h00, 2'd0, 1'b0, 1'b0, 13'h1305},
        {4'd2, 8'hFF, 2'd0, 1'b0, 1'b0, 13'h13FF},
        {4'd4, 8'h10, 2'd0, 1'b0, 1'b0, 13'h1310},
        {4'd6, 8'h00, 2'd0, 1'b0, 1'b0, 13'h1300},
        {4'd3, 8'h11, 2'd2, 1'b0, 1'b0, 13'h1301}
    };

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic clr();
        step_en = 0; pset_en = 0; jmp_en = 0; cjmp_en = 0; call_en = 0;
        calz_en = 0; ret_en = 0; rets_en = 0; irq_en = 0;
    endtask

    task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic apply(input int op, input logic [7:0] arg, input logic [1:0] kind,
                         input logic c, input logic z);
        @(negedge clk);
        clr();
        operand = arg; pset_arg = arg[4:0]; irq_vec = arg[3:0];
        cjmp_kind = kind; flag_c = c; flag_z = z;
        case (op)
            0: step_en = 1;
            1: pset_en = 1;
            2: jmp_en = 1;
            3: cjmp_en = 1;
            4: call_en = 1;
            5: calz_en = 1;
            6: ret_en = 1;
            7: rets_en = 1;
            default: irq_en = 1;
        endcase
        @(negedge clk);
        clr();
        wait_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog got busy=%0b exp idle", busy);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] prev;
        logic [7:0]  rstep;
        clr();
        operand = 0; pset_arg = 0; irq_vec = 0; cjmp_kind = 0; flag_c = 0; flag_z = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 reset address", fetch_addr, 13'h0100);
        check("R1 reset busy", {12'd0, busy}, 13'd0);

        prev = 13'h0100;
        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            int op;
            v  = VEC[i];
            op = int'(v[28:25]);
            apply(op, v[24:17], v[16:15], v[14], v[13]);
            check(tag_of(op), fetch_addr, v[12:0]);
            if (op == 4 || op == 5 || op == 8) begin
                rstep = (op == 8) ? prev[7:0] : 8'(prev[7:0] + 8'd1);
                check({tag_of(op), " pushed frame"}, {1'b0, bslot[2], bslot[1], bslot[0]},
                      {1'b0, prev[11:8], rstep});
            end
            prev = v[12:0];
        end

        // R10: strobes raised during a call's push are ignored
        @(negedge clk);
        operand = 8'h44; call_en = 1;
        @(negedge clk);
        clr(); step_en = 1; jmp_en = 1; operand = 8'h99;
        @(negedge clk);
        clr();
        wait_idle();
        check("R10 strobes ignored while busy", fetch_addr, 13'h1344);
        check("R6 frame from step 01", {1'b0, bslot[2], bslot[1], bslot[0]}, 13'h0302);

        // R11: jump outranks step, interrupt outranks call
        @(negedge clk);
        step_en = 1; jmp_en = 1; operand = 8'h77;
        @(negedge clk);
        clr();
        check("R11 jump over step", fetch_addr, 13'h1377);
        @(negedge clk);
        irq_en = 1; call_en = 1; irq_vec = 4'd9; operand = 8'h12;
        @(negedge clk);
        clr();
        wait_idle();
        check("R11 interrupt over call", fetch_addr, 13'h1109);

        // R1: reset in mid-run clears address and pending page-set
        apply(1, 8'h1F, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 reset mid-run", fetch_addr, 13'h0100);
        apply(2, 8'h22, 2'd0, 1'b0, 1'b0);
        check("R1 pending page-set dropped by reset", fetch_addr, 13'h0122);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule